// File: doc/BRIEF.md
# Atomic-Aware Memory Command Port

This block sits between a load/store unit and a memory bus. It accepts one decoded memory operation at a time and turns it into a bus command. The command depends on the operation's atomic flags: a linked read becomes a load-locked command, and a write becomes a swap, a store-conditional or a plain write. The port holds at most one request. If the bus refuses a request, the port blocks and accepts no new work until a retry pulse arrives. It then sends the held request again.

The block keeps a link register: a valid bit and the address of a line. A completed load-locked access sets the link. A later store-conditional is sent to the bus only if the link is valid and its line matches the store's line. Otherwise the store-conditional is finished locally, with no bus traffic, and reports failure on the completion output. Any completed write, swap or store-conditional to the linked line clears the link.

Top module: `memcmd_port`

## Requirements
- R1: After reset, `op_ready` is 1, and `bus_valid` and `done_valid` are 0.
- R2: A read is sent with `bus_cmd` 0 when `op_llsc` is 0, and with `bus_cmd` 1 (load-locked) when `op_llsc` is 1. `bus_addr` equals the operation's address.
- R3: A write is sent with `bus_cmd` 3 (swap) when `op_swap` is 1, whatever `op_llsc` is. Otherwise it is sent with `bus_cmd` 4 (store-conditional) when `op_llsc` is 1, and with `bus_cmd` 2 (plain write) when `op_llsc` is 0.
- R4: A cycle in which `bus_valid` is 1 and `bus_accept` is 0 is a refusal. From the next cycle on, `bus_valid` and `op_ready` stay 0 until a retry pulse. Operations offered during that time are not taken.
- R5: A `bus_retry` pulse while the port is blocked raises `bus_valid` in the next cycle, with the same command and address as before.
- R6: An operation is taken when `op_valid` and `op_ready` are both 1. `op_ready` then stays 0 until the completion. A `rsp_valid` that arrives after the bus has accepted the request gives a one-cycle `done_valid`, with `done_ok` 1, in the following cycle.
- R7: When a load-locked access completes, the link becomes valid for the line `addr[ADDR_W-1:OFFS_W]`.
- R8: A store-conditional is finished locally when the link is invalid or holds a different line. In that case `bus_valid` stays 0, and `done_valid` is 1 with `done_ok` 0 in the cycle after the operation is taken.
- R9: A store-conditional whose line matches a valid link is sent on the bus and completes with `done_ok` 1. Its completion clears the link.
- R10: A completed plain write or swap to the linked line clears the link. A completed write to any other line leaves the link as it was.
- R11: `rsp_valid` is ignored unless the port is waiting for a response. `bus_retry` is ignored unless the port is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The port can take an operation |
| op_write | input | 1 | 1 for a write, 0 for a read |
| op_llsc | input | 1 | Linked-access flag: load-linked on a read, store-conditional on a write |
| op_swap | input | 1 | Swap flag; applies to writes only |
| op_addr | input | ADDR_W | Byte address of the operation |
| bus_valid | output | 1 | A request is presented to the bus |
| bus_cmd | output | 3 | Command: 0 read, 1 load-locked, 2 write, 3 swap, 4 store-conditional |
| bus_addr | output | ADDR_W | Address of the request |
| bus_accept | input | 1 | The bus takes the request; when 0 with `bus_valid`, the bus refuses it |
| bus_retry | input | 1 | Pulse: the bus can take a refused request again |
| rsp_valid | input | 1 | The memory response for the outstanding request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Completion outcome: 1 if the access was issued, 0 if a store-conditional failed |

## Verification
The bench builds the block with its default parameters: 32 address bits and 4 offset bits, which gives 16-byte lines. With that line size, addresses such as 0x200 and 0x208 fall on the same line and 0x300 falls on another. This lets the bench check the link comparison from both sides, with store-conditionals that hit the link and ones that miss it. A behavioural model runs through the refusal, retry and ignored-pulse sequences alongside the design and compares its outputs every cycle.

// File: rtl/memcmd_port.sv
module memcmd_port #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_write,
  input  logic              op_llsc,
  input  logic              op_swap,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              bus_valid,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_accept,
  input  logic              bus_retry,
  input  logic              rsp_valid,
  output logic              done_valid,
  output logic              done_ok
);
  localparam int LINE_W = ADDR_W - OFFS_W;
  localparam logic [2:0] C_RD = 3'd0, C_LL = 3'd1, C_WR = 3'd2, C_SWP = 3'd3, C_SC = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_BLK} st_t;
  st_t st;

  logic              link_vld;
  logic [LINE_W-1:0] link_line;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;

  wire [2:0] op_cmd = !op_write ? (op_llsc ? C_LL : C_RD)
                    : op_swap   ? C_SWP
                    : op_llsc   ? C_SC : C_WR;
  wire take     = op_valid && op_ready;
  wire link_hit = link_vld && (op_addr[ADDR_W-1:OFFS_W] == link_line);
  wire sc_fail  = (op_cmd == C_SC) && !link_hit;
  wire same_ln  = addr_q[ADDR_W-1:OFFS_W] == link_line;

  assign op_ready  = (st == S_IDLE);
  assign bus_valid = (st == S_SEND);
  assign bus_cmd   = cmd_q;
  assign bus_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      link_vld   <= 1'b0;
      link_line  <= '0;
      cmd_q      <= C_RD;
      addr_q     <= '0;
      done_valid <= 1'b0;
      done_ok    <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (sc_fail) begin
            done_valid <= 1'b1;
            done_ok    <= 1'b0;
          end else begin
            cmd_q  <= op_cmd;
            addr_q <= op_addr;
            st     <= S_SEND;
          end
        end
        S_SEND: st <= bus_accept ? S_WAIT : S_BLK;
        S_WAIT: if (rsp_valid) begin
          done_valid <= 1'b1;
          done_ok    <= 1'b1;
          st         <= S_IDLE;
          if (cmd_q == C_LL) begin
            link_vld  <= 1'b1;
            link_line <= addr_q[ADDR_W-1:OFFS_W];
          end else if (cmd_q != C_RD && same_ln) begin
            link_vld <= 1'b0;
          end
        end
        S_BLK: if (bus_retry) st <= S_SEND;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_cmd <= C_SC);

  assert_refuse_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_accept) |=> (!bus_valid && !op_ready));

  assert_retry_resends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BLK && bus_retry) |=> bus_valid);

  assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !op_ready);

  assert_sc_fail_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ok) |-> $past(op_valid && op_write && op_llsc && !op_swap));

  assert_fail_no_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ok) |-> !bus_valid);
endmodule

// File: tb/tb_memcmd_port.sv
module tb_memcmd_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_write = 0, op_llsc = 0, op_swap = 0;
  logic [31:0] op_addr = '0;
  logic bus_accept = 0, bus_retry = 0, rsp_valid = 0;
  logic op_ready, bus_valid, done_valid, done_ok;
  logic [2:0] bus_cmd;
  logic [31:0] bus_addr;

  memcmd_port #(.ADDR_W(32), .OFFS_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_write(op_write), .op_llsc(op_llsc), .op_swap(op_swap), .op_addr(op_addr),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_accept(bus_accept), .bus_retry(bus_retry), .rsp_valid(rsp_valid),
    .done_valid(done_valid), .done_ok(done_ok));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  int phase = 0;
  int m_cmd = 0;
  logic [31:0] m_addr = '0;
  bit m_lv = 0;
  logic [27:0] m_line = '0;
  bit m_done = 0, m_ok = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; m_lv = 0; m_done = 0; m_ok = 0;
    end else begin
      m_done = 0;
      if (phase == 0) begin
        if (op_valid) begin
          int c;
          if (!op_write) c = op_llsc ? 1 : 0;
          else if (op_swap) c = 3;
          else if (op_llsc) c = 4;
          else c = 2;
          if (c == 4 && !(m_lv && m_line == op_addr[31:4])) begin
            m_done = 1; m_ok = 0;
          end else begin
            m_cmd = c; m_addr = op_addr; phase = 1;
          end
        end
      end else if (phase == 1) begin
        phase = bus_accept ? 2 : 3;
      end else if (phase == 2) begin
        if (rsp_valid) begin
          m_done = 1; m_ok = 1; phase = 0;
          if (m_cmd == 1) begin m_lv = 1; m_line = m_addr[31:4]; end
          else if (m_cmd != 0 && m_line == m_addr[31:4]) m_lv = 0;
        end
      end else begin
        if (bus_retry) phase = 1;
      end
    end
  end

  task automatic check1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check1("op_ready", int'(op_ready), int'(phase == 0));
    check1("bus_valid", int'(bus_valid), int'(phase == 1));
    if (phase == 1) begin
      check1("bus_cmd", int'(bus_cmd), m_cmd);
      check1("bus_addr", int'(bus_addr), int'(m_addr));
    end
    check1("done_valid", int'(done_valid), int'(m_done));
    if (m_done) check1("done_ok", int'(done_ok), int'(m_ok));
  endtask

  task automatic cyc(bit ov, bit w, bit ll, bit sw, logic [31:0] a,
                     bit acc, bit rsp, bit rty);
    op_valid = ov; op_write = w; op_llsc = ll; op_swap = sw; op_addr = a;
    bus_accept = acc; rsp_valid = rsp; bus_retry = rty;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 32'h0, 0, 0, 0);
  endtask

  task automatic full_op(bit w, bit ll, bit sw, logic [31:0] a);
    cyc(1, w, ll, sw, a, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    idle();
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; compare();
    idle();
    cur_req = "R2"; full_op(0, 0, 0, 32'h100);
    cur_req = "R7"; full_op(0, 1, 0, 32'h200);
    cur_req = "R8";
    cyc(1, 1, 1, 0, 32'h300, 0, 0, 0);
    idle();
    cur_req = "R9"; full_op(1, 1, 0, 32'h208);
    cyc(1, 1, 1, 0, 32'h200, 0, 0, 0);
    idle();
    cur_req = "R3"; full_op(1, 0, 0, 32'h340);
    full_op(1, 1, 1, 32'h344);
    cur_req = "R10";
    full_op(0, 1, 0, 32'h400);
    full_op(1, 0, 0, 32'h500);
    full_op(1, 1, 0, 32'h404);
    full_op(0, 1, 0, 32'h400);
    full_op(1, 0, 1, 32'h40c);
    cyc(1, 1, 1, 0, 32'h400, 0, 0, 0);
    idle();
    cur_req = "R4";
    cyc(1, 1, 0, 0, 32'h600, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 32'h700, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    cur_req = "R5";
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cur_req = "R6";
    cyc(1, 0, 0, 0, 32'h800, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle();
    cur_req = "R11";
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    full_op(0, 0, 0, 32'h900);
    idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule